// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing half of an on-chip byte store that behaves like a two-wire serial EEPROM. It watches a serial clock line and a serial data line, both already synchronised to the fast system clock. It pulls the data line low through an open-drain style output whenever it acknowledges or sends a zero bit. It recognises start and stop conditions and checks the device address against a fixed prefix and two strap inputs. It then handles byte and multi-byte writes, current-address reads, random reads and sequential reads.

The byte storage and the buffering and commit of written data sit in a neighbouring block. This controller gives that block a write strobe with address and data for each accepted byte, and a single commit pulse when a write transfer closes with a stop. It reads back bytes through a plain address/data port. The neighbour reports an ongoing internal write on `wr_busy_i`. While that input is high the controller ignores its own address, so a master can poll until the write is done. A word pointer inside the controller is kept between transfers. A parameter picks the 32K-byte default size or the 16K-byte size.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data line is released, and neither the write strobe nor the commit pulse is active.
- R2: A device address byte is acknowledged only when its bits 7..3 are 1,0,1,0,0 and its bits 2..1 equal `addr_sel_i[1:0]`. Bit 0 is 1 for read and 0 for write. On a mismatch the block stays silent and ignores the bus until the next start.
- R3: In a matched write transfer, every received byte (device address, both word-address bytes, data) is acknowledged by pulling the data line low for the ninth clock period. The data line only changes while the clock is low, except when a start or stop resets it.
- R4: A write transfer sends the word address high byte first, then the low byte. The bits above the array's address width are ignored. Each data byte gives one single-cycle write strobe carrying the current pointer and the byte.
- R5: After each written byte the pointer's low 6 bits count up and wrap inside the 64-byte page. The upper bits do not change.
- R6: A stop after at least one accepted data byte gives exactly one commit pulse. A stop with no data byte gives none. A start that interrupts a write transfer drops its commit.
- R7: While `wr_busy_i` is high the device address is not acknowledged. Once it is low, the address is acknowledged again.
- R8: A random read (write transfer carrying only the word address, repeated start, read address) returns the byte stored at that address.
- R9: A current-address read returns the byte at the stored pointer, which holds the last accessed address plus one, kept across transfers.
- R10: While the master acknowledges, reading continues with the next address. The pointer wraps from the last byte of the array to address 0.
- R11: When the master does not acknowledge a read byte, the block releases the data line and stays released until the next start or stop.
- R12: While `wp_i` is high, data bytes are still acknowledged, but no write strobe and no commit pulse are produced.
- R13: A start seen in any state, including inside a byte, aborts the transfer and restarts device-address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (wired level) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Strapped device address bits (bit 1, bit 0) |
| wp_i | input | 1 | Write protect, 1 blocks writes |
| wr_busy_i | input | 1 | Neighbour is committing a write |
| mem_addr_o | output | ADDR_W | Read address, or write address during the strobe |
| mem_rdata_i | input | 8 | Byte at `mem_addr_o` |
| mem_wr_o | output | 1 | Single-cycle write strobe |
| mem_wdata_o | output | 8 | Byte to write |
| wr_commit_o | output | 1 | Single-cycle commit pulse at a stop |

## Verification
A wrong state or bit count inside the controller shows up at the bus within one byte time, about nine clock periods. It appears as an acknowledge in the wrong slot, a missing acknowledge, or read bits shifted by one position. A pointer that has gone astray does not show up until the next read, where the returned byte belongs to a different address. Because of that, every write scenario is followed by a read or by a direct look at the memory model. Errors in the strobe or commit pulses appear on the memory-side ports within a cycle of the ninth clock edge or of the stop.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_AHI,
        S_ALO,
        S_WDAT,
        S_ACK,
        S_RD,
        S_MACK,
        S_RNEXT,
        S_HOLD
    } ee_state_e;

    typedef struct packed {
        ee_state_e  st;
        ee_state_e  nxt;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] hi;
        logic       pull;
        logic       ack_on;
        logic       pend;
        logic       wr_inc;
        logic       we;
        logic [7:0] wdata;
        logic       commit;
    } ee_ctl_t;

    localparam logic [4:0] DEV_PREFIX = 5'b10100;

endpackage

// File: rtl/ee_bus_events.sv
module ee_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_d, scl_q;
    logic sda_d, sda_q;

    always_comb begin
        scl_d = scl_i;
        sda_d = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign bus_start = scl_i & scl_q & sda_q & ~sda_i;
    assign bus_stop  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/ee_word_ptr.sv
module ee_word_ptr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] ptr_d, ptr_q;
    logic [ADDR_W-1:0] page_next;

    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            assign page_next = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
        end else begin : g_flat
            assign page_next = ptr_q + 1'b1;
        end
    endgenerate

    always_comb begin
        ptr_d = ptr_q;
        if (load)          ptr_d = load_val;
        else if (inc_full) ptr_d = ptr_q + 1'b1;
        else if (inc_page) ptr_d = page_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R5: page increments keep the row bits
    a_r5_page_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inc_page && !load && !inc_full) |->
            ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));

    // R10: full-array increment wraps from top to zero
    a_r10_array_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc_full && !load) && $past(ptr_q) == {ADDR_W{1'b1}}) |->
            ptr_q == '0);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int MEM_BYTES  = 32768,
    parameter int PAGE_BYTES = 64,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [1:0]        addr_sel_i,
    input  logic              wp_i,
    input  logic              wr_busy_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              mem_wr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              wr_commit_o
);
    import ee_pkg::*;

    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic              ptr_load, inc_page, inc_full;
    logic [ADDR_W-1:0] ptr_val, ptr;
    logic [7:0]        rx_byte;
    ee_ctl_t           d, q;

    ee_bus_events u_ev (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    ee_word_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_val),
        .inc_page (inc_page),
        .inc_full (inc_full),
        .ptr      (ptr)
    );

    assign rx_byte = {q.sh[6:0], sda_i};

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        d.commit = 1'b0;
        ptr_load = 1'b0;
        ptr_val  = ADDR_W'({q.hi, rx_byte});
        inc_page = 1'b0;
        inc_full = 1'b0;

        if (bus_start) begin
            d.st     = S_DEV;
            d.cnt    = '0;
            d.pull   = 1'b0;
            d.ack_on = 1'b0;
            d.pend   = 1'b0;
            d.wr_inc = 1'b0;
        end else if (bus_stop) begin
            d.st     = S_IDLE;
            d.pull   = 1'b0;
            d.ack_on = 1'b0;
            d.commit = q.pend;
            d.pend   = 1'b0;
            d.wr_inc = 1'b0;
        end else begin
            unique case (q.st)
                S_DEV, S_AHI, S_ALO, S_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = rx_byte;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == 4'd7) begin
                            d.cnt    = '0;
                            d.st     = S_ACK;
                            d.ack_on = 1'b0;
                            unique case (q.st)
                                S_DEV: begin
                                    if (rx_byte[7:3] == DEV_PREFIX &&
                                        rx_byte[2:1] == addr_sel_i && !wr_busy_i)
                                        d.nxt = rx_byte[0] ? S_RD : S_AHI;
                                    else
                                        d.st = S_IDLE;
                                end
                                S_AHI: begin
                                    d.hi  = rx_byte;
                                    d.nxt = S_ALO;
                                end
                                S_ALO: begin
                                    ptr_load = 1'b1;
                                    d.nxt    = S_WDAT;
                                end
                                default: begin
                                    d.nxt    = S_WDAT;
                                    d.wr_inc = 1'b1;
                                    if (!wp_i) begin
                                        d.we    = 1'b1;
                                        d.wdata = rx_byte;
                                        d.pend  = 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        if (!q.ack_on) begin
                            d.ack_on = 1'b1;
                            d.pull   = 1'b1;
                            inc_page = q.wr_inc;
                            d.wr_inc = 1'b0;
                        end else begin
                            d.ack_on = 1'b0;
                            d.pull   = 1'b0;
                            d.st     = q.nxt;
                            d.cnt    = '0;
                            if (q.nxt == S_RD) begin
                                d.sh   = mem_rdata_i;
                                d.pull = ~mem_rdata_i[7];
                            end
                        end
                    end
                end
                S_RD: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == 4'd7) inc_full = 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.pull = 1'b0;
                            d.st   = S_MACK;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.pull = ~q.sh[6];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) d.st = sda_i ? S_HOLD : S_RNEXT;
                end
                S_RNEXT: begin
                    if (scl_fall) begin
                        d.st   = S_RD;
                        d.cnt  = '0;
                        d.sh   = mem_rdata_i;
                        d.pull = ~mem_rdata_i[7];
                    end
                end
                default: begin
                    d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, nxt: S_IDLE, cnt: '0, sh: '0, hi: '0,
                   pull: 1'b0, ack_on: 1'b0, pend: 1'b0, wr_inc: 1'b0,
                   we: 1'b0, wdata: '0, commit: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o  = q.pull;
    assign mem_addr_o  = ptr;
    assign mem_wr_o    = q.we;
    assign mem_wdata_o = q.wdata;
    assign wr_commit_o = q.commit;

    // R3: data line only moves while the clock is low, unless a start or stop reset it
    a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(sda_pull_o) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_i);

    // R4: each write strobe lasts a single cycle
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> !mem_wr_o);

    // R6: commit is a single-cycle pulse that follows a stop
    a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> ($past(bus_stop) && !$past(wr_commit_o)));

    // R12: no strobe while protected
    a_r12_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> !$past(wp_i));

endmodule

// File: tb/i2c_eeprom_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_test;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        wp = 1'b0;
    logic        busy;
    logic        sda_pull;
    logic [14:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        commit;
    wire         sda = sda_m & ~sda_pull;

    int checks = 0, fails = 0, commits = 0, busy_cnt = 0;
    logic [7:0] model [int];

    always #2 clk = ~clk;

    i2c_eeprom_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda),
        .sda_pull_o(sda_pull), .addr_sel_i(2'b10), .wp_i(wp),
        .wr_busy_i(busy), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .wr_commit_o(commit)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(a) ^ 8'h3C ^ 8'((a >> 8) & 8'h7F);
    endfunction

    function automatic logic [7:0] rd_model(int a);
        if (model.exists(a)) return model[a];
        return pat(a);
    endfunction

    assign busy = (busy_cnt != 0);

    always @(posedge clk) begin
        mem_rdata <= rd_model(int'(mem_addr));
        if (mem_wr) model[int'(mem_addr)] = mem_wdata;
        if (commit) begin
            commits  <= commits + 1;
            busy_cnt <= 600;
        end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2);
        ackd = (sda == 1'b0);
        tick(H/2); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(H); scl_m = 1'b1; tick(H/2);
            b = {b[6:0], sda};
            tick(H/2); scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic addr_phase(input int a, output logic all_ack);
        logic k0, k1, k2;
        bus_start;
        send_byte(8'hA4, k0);
        send_byte(8'(a >> 8), k1);
        send_byte(8'(a), k2);
        all_ack = k0 & k1 & k2;
    endtask

    task automatic t_reset;
        chk(sda_pull == 1'b0, "R1 sda released", int'(sda_pull), 0);
        chk(mem_wr == 1'b0 && commit == 1'b0, "R1 strobes idle", int'({mem_wr, commit}), 0);
    endtask

    task automatic t_mismatch;
        logic k;
        bus_start;
        send_byte(8'hA2, k);
        chk(!k, "R2 wrong strap bits", int'(k), 0);
        send_byte(8'hA4, k);
        chk(!k, "R2 ignored until start", int'(k), 0);
        bus_start;
        send_byte(8'hB4, k);
        chk(!k, "R2 wrong prefix", int'(k), 0);
        bus_stop;
    endtask

    task automatic t_byte_write_poll;
        logic k, ka;
        int c0;
        c0 = commits;
        addr_phase(16'h1234, ka);
        send_byte(8'h5C, k);
        chk(ka && k, "R3 write bytes acked", int'({ka, k}), 3);
        bus_stop; tick(2);
        chk(rd_model(16'h1234) == 8'h5C, "R4 byte stored", int'(rd_model(16'h1234)), 8'h5C);
        chk(commits == c0 + 1, "R6 one commit", commits, c0 + 1);
        bus_start;
        send_byte(8'hA4, k);
        chk(!k, "R7 silent while busy", int'(k), 0);
        bus_stop;
        tick(700);
        bus_start;
        send_byte(8'hA4, k);
        chk(k, "R7 acks after busy", int'(k), 1);
        bus_stop; tick(4);
        chk(commits == c0 + 1, "R6 no commit without data", commits, c0 + 1);
    endtask

    task automatic t_random_read(input int a, input logic [7:0] exp, input string req);
        logic k, ka;
        logic [7:0] b;
        addr_phase(a, ka);
        bus_start;
        send_byte(8'hA5, k);
        recv_byte(1'b0, b);
        bus_stop;
        chk(ka && k && b == exp, req, int'(b), int'(exp));
    endtask

    task automatic t_current_read(input logic [7:0] exp);
        logic k;
        logic [7:0] b;
        bus_start;
        send_byte(8'hA5, k);
        recv_byte(1'b0, b);
        bus_stop;
        chk(k && b == exp, "R9 current read", int'(b), int'(exp));
    endtask

    task automatic t_seq_wrap;
        logic k, ka;
        logic [7:0] b0, b1, b2;
        model[32767] = 8'h99;
        model[0]     = 8'h66;
        addr_phase(16'h7FFE, ka);
        bus_start;
        send_byte(8'hA5, k);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        bus_stop;
        chk(b0 == pat(16'h7FFE), "R10 seq first", int'(b0), int'(pat(16'h7FFE)));
        chk(b1 == 8'h99, "R10 seq top", int'(b1), 8'h99);
        chk(b2 == 8'h66, "R10 seq wrap to zero", int'(b2), 8'h66);
        t_current_read(pat(1));
    endtask

    task automatic t_nack_release;
        logic k, ka;
        logic [7:0] b;
        int lows = 0;
        addr_phase(16'h0010, ka);
        bus_start;
        send_byte(8'hA5, k);
        recv_byte(1'b0, b);
        for (int i = 0; i < 9; i++) begin
            tick(H); scl_m = 1'b1; tick(H/2);
            if (sda == 1'b0) lows++;
            tick(H/2); scl_m = 1'b0;
        end
        bus_stop;
        chk(lows == 0, "R11 line released after nack", lows, 0);
    endtask

    task automatic t_page_wrap;
        logic k0, k1, k2, ka;
        addr_phase(16'h013E, ka);
        send_byte(8'h11, k0);
        send_byte(8'h22, k1);
        send_byte(8'h33, k2);
        bus_stop; tick(2);
        chk(rd_model(16'h013F) == 8'h22, "R5 page byte", int'(rd_model(16'h013F)), 8'h22);
        chk(rd_model(16'h0100) == 8'h33, "R5 page wrap", int'(rd_model(16'h0100)), 8'h33);
        chk(!model.exists(16'h0140), "R5 next page untouched", 1, 0);
        tick(700);
    endtask

    task automatic t_upper_ignored;
        logic k, ka;
        addr_phase(16'h8123, ka);
        send_byte(8'h77, k);
        bus_stop; tick(2);
        chk(rd_model(16'h0123) == 8'h77, "R4 upper bit ignored", int'(rd_model(16'h0123)), 8'h77);
        tick(700);
    endtask

    task automatic t_protect;
        logic k, ka;
        int c0;
        c0 = commits;
        wp = 1'b1;
        addr_phase(16'h0200, ka);
        send_byte(8'hEE, k);
        bus_stop; tick(4);
        wp = 1'b0;
        chk(k, "R12 data still acked", int'(k), 1);
        chk(!model.exists(16'h0200), "R12 no store", int'(rd_model(16'h0200)), int'(pat(16'h0200)));
        chk(commits == c0, "R12 no commit", commits, c0);
    endtask

    task automatic t_start_abort;
        logic k, ka;
        logic [7:0] b;
        int c0;
        c0 = commits;
        bus_start;
        send_byte(8'hA4, k);
        send_byte(8'h02, k);
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
        end
        bus_start;
        send_byte(8'hA5, k);
        chk(k, "R13 start mid byte restarts", int'(k), 1);
        recv_byte(1'b0, b);
        bus_stop;
        addr_phase(16'h0300, ka);
        send_byte(8'h44, k);
        bus_start;
        send_byte(8'hA5, k);
        recv_byte(1'b0, b);
        bus_stop; tick(4);
        chk(k && b == pat(16'h0301), "R13 read after restart", int'(b), int'(pat(16'h0301)));
        chk(commits == c0, "R6 start drops commit", commits, c0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset;
        t_mismatch;
        t_byte_write_poll;
        t_random_read(16'h1234, 8'h5C, "R8 random read");
        t_current_read(pat(16'h1235));
        t_seq_wrap;
        t_nack_release;
        t_page_wrap;
        t_upper_ignored;
        t_protect;
        t_start_abort;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule